// File: doc/BRIEF.md
# Sensor Configuration Read-Modify-Write Sequencer

This block drives a motion sensor's control registers without a processor in the loop. It sits on top of an SPI register access master that carries out one single-byte transaction per request, and turns a short command into the sequence of register reads and writes that command needs. An initialisation command writes two ready-made control bytes to two fixed registers. Every field update is an atomic read, mask, OR, write: the target register is read, the bits outside a field-specific keep mask are cleared, the new field value is ORed in, and the result is written back.

A host raises `cmd_valid` with an operation code and up to two argument bytes. While a sequence runs, `busy` is high and further commands are refused. The end of every command, whether it succeeded, was aborted or was reserved, is marked by a one-cycle `done` pulse, with `err` telling the outcome. Only one lower-level transaction is in flight at any time, and a write whose data depends on a read is issued only after that read has returned.

Top module: `cfg_rmw_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `req_start` are all low.
- R2: Operation 0 (init) performs exactly two writes and no read: first address 0x20 gets `cmd_arg_a`, then address 0x23 gets `cmd_arg_b`.
- R3: Operation 1 reads address 0x22 and writes back (old AND 0x7F) OR `cmd_arg_a`.
- R4: Operation 2 reads address 0x22 and writes back (old AND 0xF7) OR `cmd_arg_a`.
- R5: Operation 3 reads address 0x24 and writes back (old AND 0xEF) OR `cmd_arg_a`; operation 4 reads address 0x21 and writes back (old AND 0xC0) OR `cmd_arg_a`.
- R6: Operation 5 performs, in this order, a read of 0x30, a read of 0x22, a write of (old 0x30 AND 0x80) OR `cmd_arg_a` to 0x30, and a write of (old 0x22 AND 0xDF) OR `cmd_arg_b` to 0x22.
- R7: Operation 6 reads address 0x24 and writes back the old value with bit 7 set; both argument bytes are ignored.
- R8: Each step is a separate single-byte request (`req_rd` high for read, low for write); a new `req_start` is never raised before the previous request has received `rsp_done` or `rsp_timeout`, so each read completes before the write that uses it.
- R9: `done` is a one-cycle pulse; `busy` rises the cycle after a command is accepted and stays high up to and including the `done` cycle, then falls.
- R10: A command presented while `busy` is high is refused: it starts no transaction, alters no register and does not change the running sequence's data.
- R11: `rsp_timeout` aborts the sequence: no further request is issued, `done` pulses with `err` high, and `err` clears when the next valid command is accepted.
- R12: Operation 7 is reserved: it issues no request and ends with `done` and `err` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken only while idle |
| cmd_op | input | 3 | Operation code |
| cmd_arg_a | input | 8 | First argument byte |
| cmd_arg_b | input | 8 | Second argument byte |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| err | output | 1 | Last command aborted or reserved |
| req_start | output | 1 | One-cycle request to the lower master |
| req_rd | output | 1 | Request direction, 1 = read |
| req_addr | output | 7 | Register address of the request |
| req_wdata | output | 8 | Write byte of the request |
| rsp_done | input | 1 | Lower master finished the request |
| rsp_timeout | input | 1 | Lower master gave up on the request |
| rsp_rdata | input | 8 | Byte returned by a read |

## Verification
A wrong keep mask, slot selection or step table shows up as a register value in the bench's sensor model that differs from the bench's own merge, visible as soon as `done` pulses after that command. A corrupted step index or a wrong ordering shows as a transaction log with the wrong count, direction or address, and an issue while a request is outstanding is counted by the model in the very cycle it happens. A stuck state machine shows as a missing `done`, caught by the per-command wait limit.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  localparam int BYTE_W = 8;
  localparam int OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_INIT     = 3'd0,
    OP_INT1_EN  = 3'd1,
    OP_INT2_EN  = 3'd2,
    OP_HPF_EN   = 3'd3,
    OP_HPF_CFG  = 3'd4,
    OP_INT_CFG  = 3'd5,
    OP_REBOOT   = 3'd6,
    OP_RSVD     = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_WAIT  = 2'd2,
    S_FIN   = 2'd3
  } st_e;

  // symbolic register targets, mapped to addresses at the top level
  typedef enum logic [2:0] {
    RG_CTL1 = 3'd0,
    RG_CTL2 = 3'd1,
    RG_CTL3 = 3'd2,
    RG_CTL4 = 3'd3,
    RG_CTL5 = 3'd4,
    RG_ICFG = 3'd5
  } rg_e;

  typedef struct packed {
    logic              rd;
    logic              slot;
    rg_e               rg;
    logic [BYTE_W-1:0] keep;
    logic [BYTE_W-1:0] orv;
    logic              last;
  } step_t;

endpackage

// File: rtl/cfg_seq_prog.sv
module cfg_seq_prog
  import cfg_seq_pkg::*;
#(
  parameter int                STEPS     = 4,
  parameter logic [BYTE_W-1:0] BOOT_MASK = 8'h80,
  localparam int               IDX_W     = $clog2(STEPS)
) (
  input  logic [OP_W-1:0]   op,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] arg_a,
  input  logic [BYTE_W-1:0] arg_b,
  output step_t             step
);

  function automatic step_t mk(input logic rd, input logic slot, input rg_e rg,
                               input logic [BYTE_W-1:0] keep,
                               input logic [BYTE_W-1:0] orv, input logic last);
    step_t s;
    s.rd   = rd;
    s.slot = slot;
    s.rg   = rg;
    s.keep = keep;
    s.orv  = orv;
    s.last = last;
    return s;
  endfunction

  // single-register update: read into slot 0, then merge and write
  function automatic step_t rmw(input logic [IDX_W-1:0] i, input rg_e rg,
                                input logic [BYTE_W-1:0] keep,
                                input logic [BYTE_W-1:0] orv);
    if (i == '0) return mk(1'b1, 1'b0, rg, '0, '0, 1'b0);
    return mk(1'b0, 1'b0, rg, keep, orv, 1'b1);
  endfunction

  always_comb begin
    step = mk(1'b0, 1'b0, RG_CTL1, '0, '0, 1'b1);
    unique case (op_e'(op))
      OP_INIT: begin
        if (idx == '0) step = mk(1'b0, 1'b0, RG_CTL1, '0, arg_a, 1'b0);
        else           step = mk(1'b0, 1'b0, RG_CTL4, '0, arg_b, 1'b1);
      end
      OP_INT1_EN: step = rmw(idx, RG_CTL3, 8'h7F, arg_a);
      OP_INT2_EN: step = rmw(idx, RG_CTL3, 8'hF7, arg_a);
      OP_HPF_EN:  step = rmw(idx, RG_CTL5, 8'hEF, arg_a);
      OP_HPF_CFG: step = rmw(idx, RG_CTL2, 8'hC0, arg_a);
      OP_REBOOT:  step = rmw(idx, RG_CTL5, 8'hFF, BOOT_MASK);
      OP_INT_CFG: begin
        // both reads first, config register written before control 3
        case (idx)
          2'd0:    step = mk(1'b1, 1'b0, RG_ICFG, '0, '0, 1'b0);
          2'd1:    step = mk(1'b1, 1'b1, RG_CTL3, '0, '0, 1'b0);
          2'd2:    step = mk(1'b0, 1'b0, RG_ICFG, 8'h80, arg_a, 1'b0);
          default: step = mk(1'b0, 1'b1, RG_CTL3, 8'hDF, arg_b, 1'b1);
        endcase
      end
      default: step = mk(1'b0, 1'b0, RG_CTL1, '0, '0, 1'b1);
    endcase
  end

endmodule

// File: rtl/cfg_seq_merge.sv
module cfg_seq_merge
  import cfg_seq_pkg::*;
#(
  parameter int  SLOTS  = 2,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [SLOT_W-1:0] slot,
  input  logic [BYTE_W-1:0] rdata,
  input  logic [BYTE_W-1:0] keep,
  input  logic [BYTE_W-1:0] orv,
  output logic [BYTE_W-1:0] wdata
);

  logic [BYTE_W-1:0] buf_q [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic ld;
    assign ld = cap_en && (slot == SLOT_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  buf_q[g] <= '0;
      else if (ld) buf_q[g] <= rdata;
    end
  end

  assign wdata = (buf_q[slot] & keep) | orv;

endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
  import cfg_seq_pkg::*;
#(
  parameter int  STEPS = 4,
  localparam int IDX_W = $clog2(STEPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [BYTE_W-1:0] cmd_arg_a,
  input  logic [BYTE_W-1:0] cmd_arg_b,
  input  logic              step_rd,
  input  logic              step_last,
  input  logic              rsp_done,
  input  logic              rsp_timeout,
  output logic [OP_W-1:0]   op_q,
  output logic [BYTE_W-1:0] a_q,
  output logic [BYTE_W-1:0] b_q,
  output logic [IDX_W-1:0]  idx_q,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              req_start,
  output logic              cap_en
);

  st_e             st_q, st_d;
  logic [IDX_W-1:0] idx_d;
  logic            err_q, err_d;
  logic            accept, rsvd_in;

  assign accept  = (st_q == S_IDLE) && cmd_valid;
  assign rsvd_in = (op_e'(cmd_op) == OP_RSVD);

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    err_d = err_q;
    unique case (st_q)
      S_IDLE: begin
        if (accept) begin
          idx_d = '0;
          err_d = rsvd_in;
          st_d  = rsvd_in ? S_FIN : S_ISSUE;
        end
      end
      S_ISSUE: st_d = S_WAIT;
      S_WAIT: begin
        if (rsp_timeout) begin
          err_d = 1'b1;
          st_d  = S_FIN;
        end else if (rsp_done) begin
          if (step_last) begin
            st_d = S_FIN;
          end else begin
            idx_d = idx_q + 1'b1;
            st_d  = S_ISSUE;
          end
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      idx_q <= '0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      err_q <= err_d;
    end
  end

  // command capture, enabled only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= '0;
      a_q  <= '0;
      b_q  <= '0;
    end else if (accept) begin
      op_q <= cmd_op;
      a_q  <= cmd_arg_a;
      b_q  <= cmd_arg_b;
    end
  end

  assign busy      = (st_q != S_IDLE);
  assign done      = (st_q == S_FIN);
  assign err       = err_q;
  assign req_start = (st_q == S_ISSUE);
  assign cap_en    = (st_q == S_WAIT) && rsp_done && !rsp_timeout && step_rd;

  a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_busy_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  a_r8_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    req_start |=> !req_start);
  a_r8_issue_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (req_start || done));
  a_r11_timeout_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WAIT && rsp_timeout) |=> (done && err));
  a_r11_err_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !rsvd_in) |=> !err);
  a_r10_args_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> ($stable(a_q) && $stable(b_q) && $stable(op_q)));

endmodule

// File: rtl/cfg_rmw_seq.sv
module cfg_rmw_seq
  import cfg_seq_pkg::*;
#(
  parameter int                ADDR_W    = 7,
  parameter logic [ADDR_W-1:0] A_CTL1    = 7'h20,
  parameter logic [ADDR_W-1:0] A_CTL2    = 7'h21,
  parameter logic [ADDR_W-1:0] A_CTL3    = 7'h22,
  parameter logic [ADDR_W-1:0] A_CTL4    = 7'h23,
  parameter logic [ADDR_W-1:0] A_CTL5    = 7'h24,
  parameter logic [ADDR_W-1:0] A_ICFG    = 7'h30,
  parameter logic [7:0]        BOOT_MASK = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [7:0]        cmd_arg_a,
  input  logic [7:0]        cmd_arg_b,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              req_start,
  output logic              req_rd,
  output logic [ADDR_W-1:0] req_addr,
  output logic [7:0]        req_wdata,
  input  logic              rsp_done,
  input  logic              rsp_timeout,
  input  logic [7:0]        rsp_rdata
);

  localparam int STEPS = 4;
  localparam int IDX_W = $clog2(STEPS);
  localparam int SLOTS = 2;

  logic [OP_W-1:0]   op_q;
  logic [BYTE_W-1:0] a_q, b_q;
  logic [IDX_W-1:0]  idx_q;
  logic              cap_en;
  step_t             step;

  cfg_seq_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_arg_a  (cmd_arg_a),
    .cmd_arg_b  (cmd_arg_b),
    .step_rd    (step.rd),
    .step_last  (step.last),
    .rsp_done   (rsp_done),
    .rsp_timeout(rsp_timeout),
    .op_q       (op_q),
    .a_q        (a_q),
    .b_q        (b_q),
    .idx_q      (idx_q),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .req_start  (req_start),
    .cap_en     (cap_en)
  );

  cfg_seq_prog #(.STEPS(STEPS), .BOOT_MASK(BOOT_MASK)) u_prog (
    .op    (op_q),
    .idx   (idx_q),
    .arg_a (a_q),
    .arg_b (b_q),
    .step  (step)
  );

  cfg_seq_merge #(.SLOTS(SLOTS)) u_merge (
    .clk   (clk),
    .rst_n (rst_n),
    .cap_en(cap_en),
    .slot  (step.slot),
    .rdata (rsp_rdata),
    .keep  (step.keep),
    .orv   (step.orv),
    .wdata (req_wdata)
  );

  always_comb begin
    unique case (step.rg)
      RG_CTL1: req_addr = A_CTL1;
      RG_CTL2: req_addr = A_CTL2;
      RG_CTL3: req_addr = A_CTL3;
      RG_CTL4: req_addr = A_CTL4;
      RG_CTL5: req_addr = A_CTL5;
      RG_ICFG: req_addr = A_ICFG;
      default: req_addr = A_CTL1;
    endcase
  end

  assign req_rd = step.rd;

  a_r12_reserved_no_request: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && cmd_op == 3'd7) |=> (done && !req_start));
  a_r2_init_writes_only: assert property (@(posedge clk) disable iff (!rst_n)
    (req_start && op_q == 3'd0) |-> !req_rd);

endmodule

// File: tb/tb_cfg_rmw_seq.sv
module tb_cfg_rmw_seq;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid;
  logic [2:0] cmd_op;
  logic [7:0] cmd_arg_a, cmd_arg_b;
  logic       busy, done, err, req_start, req_rd;
  logic [6:0] req_addr;
  logic [7:0] req_wdata;
  logic       rsp_done, rsp_timeout;
  logic [7:0] rsp_rdata;

  always #10 clk = ~clk;

  cfg_rmw_seq dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_arg_a(cmd_arg_a), .cmd_arg_b(cmd_arg_b), .busy(busy), .done(done),
    .err(err), .req_start(req_start), .req_rd(req_rd), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_timeout(rsp_timeout),
    .rsp_rdata(rsp_rdata)
  );

  int n_cmp = 0, n_bad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // sensor register model behind the lower master
  logic [7:0] mem [0:127];
  int         lat = 1;
  int         to_at = -1;
  int         tr_n = 0;
  int         overlap = 0;
  logic       pend = 1'b0;
  int         cnt = 0;
  logic       cur_rd;
  logic [6:0] cur_a;
  logic [7:0] cur_w;
  logic       log_rd [0:15];
  logic [6:0] log_a  [0:15];

  always @(negedge clk) begin
    rsp_done    = 1'b0;
    rsp_timeout = 1'b0;
    if (pend) begin
      if (cnt == 0) begin
        pend = 1'b0;
        if (tr_n - 1 == to_at) rsp_timeout = 1'b1;
        else begin
          rsp_done = 1'b1;
          if (cur_rd) rsp_rdata = mem[cur_a];
          else        mem[cur_a] = cur_w;
        end
      end else cnt--;
    end
    if (req_start === 1'b1) begin
      if (pend) overlap++;
      else begin
        cur_rd = req_rd; cur_a = req_addr; cur_w = req_wdata;
        if (tr_n < 16) begin log_rd[tr_n] = req_rd; log_a[tr_n] = req_addr; end
        tr_n++;
        pend = 1'b1;
        cnt  = lat;
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  localparam logic [6:0] AD [0:5] = '{7'h20, 7'h21, 7'h22, 7'h23, 7'h24, 7'h30};

  function automatic int n_steps(input logic [2:0] op);
    if (op == 3'd5) return 4;
    if (op == 3'd7) return 0;
    return 2;
  endfunction

  function automatic logic [7:0] exp_addr(input logic [2:0] op, input int k);
    case (op)
      3'd0: return (k == 0) ? 8'h20 : 8'h23;
      3'd1, 3'd2: return 8'h22;
      3'd3, 3'd6: return 8'h24;
      3'd4: return 8'h21;
      default: return (k == 0 || k == 2) ? 8'h30 : 8'h22;
    endcase
  endfunction

  function automatic logic exp_rd(input logic [2:0] op, input int k);
    if (op == 3'd0) return 1'b0;
    if (op == 3'd5) return (k < 2);
    return (k == 0);
  endfunction

  function automatic string rq(input logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3, 3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R12";
    endcase
  endfunction

  // runs one command; intrude=1 pokes refused commands while busy (R10)
  task automatic run(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b,
                     input bit intrude, input int abort_at);
    logic [7:0] e [0:127];
    int w;
    int ntr;
    for (int i = 0; i < 128; i++) e[i] = mem[i];
    if (abort_at < 0) begin
      case (op)
        3'd0: begin e[7'h20] = a; e[7'h23] = b; end
        3'd1: e[7'h22] = (e[7'h22] & 8'h7F) | a;
        3'd2: e[7'h22] = (e[7'h22] & 8'hF7) | a;
        3'd3: e[7'h24] = (e[7'h24] & 8'hEF) | a;
        3'd4: e[7'h21] = (e[7'h21] & 8'hC0) | a;
        3'd5: begin
          e[7'h30] = (e[7'h30] & 8'h80) | a;
          e[7'h22] = (e[7'h22] & 8'hDF) | b;
        end
        3'd6: e[7'h24] = e[7'h24] | 8'h80;
        default: ;
      endcase
    end
    ntr = (abort_at >= 0) ? abort_at + 1 : n_steps(op);
    to_at = abort_at;
    tr_n = 0; overlap = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_arg_a = a; cmd_arg_b = b;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R9 busy after accept", busy, 1'b1);
    if (intrude) begin
      for (int i = 0; i < 3; i++) begin
        if (done !== 1'b1) begin
          cmd_valid = 1'b1; cmd_op = 3'd0; cmd_arg_a = 8'h55; cmd_arg_b = 8'hAA;
          @(negedge clk);
          cmd_valid = 1'b0;
        end
      end
    end
    w = 0;
    while (done !== 1'b1 && w < 200) begin @(negedge clk); w++; end
    chk({rq(op), " done reached"}, done, 1'b1);
    chk("R9 busy during done", busy, 1'b1);
    chk("R11/R12 err at done", err, (abort_at >= 0 || op == 3'd7));
    @(negedge clk);
    chk("R9 done one cycle", done, 1'b0);
    chk("R9 busy released", busy, 1'b0);
    chk({rq(op), "/R8/R11 transaction count"}, tr_n, ntr);
    chk("R8 overlap", overlap, 0);
    for (int k = 0; k < ntr && k < 16; k++) begin
      chk({rq(op), " step direction"}, log_rd[k], exp_rd(op, k));
      chk({rq(op), " step address"}, log_a[k], exp_addr(op, k));
    end
    for (int r = 0; r < 6; r++)
      chk({rq(op), intrude ? "/R10" : "", " register value"}, mem[AD[r]], e[AD[r]]);
    to_at = -1;
  endtask

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < 128; i++) mem[i] = 8'($urandom);
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_arg_a = '0; cmd_arg_b = '0;
    rsp_rdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 1'b0);
    chk("R1 done", done, 1'b0);
    chk("R1 err", err, 1'b0);
    chk("R1 req_start", req_start, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed: every operation once, mixed latencies
    lat = 0; run(3'd0, 8'h6F, 8'h30, 1'b0, -1);
    lat = 2; run(3'd1, 8'h80, 8'h00, 1'b0, -1);
    lat = 1; run(3'd2, 8'h08, 8'hFF, 1'b0, -1);
    lat = 3; run(3'd3, 8'h10, 8'h00, 1'b0, -1);
    lat = 0; run(3'd4, 8'h25, 8'h00, 1'b0, -1);
    lat = 1; run(3'd5, 8'h6A, 8'h20, 1'b0, -1);
    lat = 2; run(3'd6, 8'h00, 8'h00, 1'b0, -1);
    lat = 0; run(3'd6, 8'hFF, 8'hFF, 1'b0, -1);
    // R12 reserved op, then R11 err cleared by the next command
    run(3'd7, 8'h12, 8'h34, 1'b0, -1);
    run(3'd1, 8'h00, 8'h00, 1'b0, -1);
    // R11 timeout on the read step and on the write step
    lat = 1; run(3'd3, 8'h10, 8'h00, 1'b0, 0);
    run(3'd2, 8'h08, 8'h00, 1'b0, 1);
    run(3'd5, 8'h01, 8'h02, 1'b0, 1);
    run(3'd4, 8'h3F, 8'h00, 1'b0, -1);
    // R10 refused commands while busy
    lat = 3; run(3'd1, 8'h80, 8'h00, 1'b1, -1);
    lat = 2; run(3'd5, 8'h7F, 8'h20, 1'b1, -1);

    // random mix
    for (int n = 0; n < 40; n++) begin
      lat = $urandom_range(0, 3);
      run(3'($urandom_range(0, 6)), 8'($urandom), 8'($urandom),
          1'($urandom_range(0, 1)), -1);
    end

    repeat (3) @(negedge clk);
    chk("R10 stays idle", busy, 1'b0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule